// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This block adds or subtracts two 32-bit operands for runtimes of dynamically typed languages, where the low bits of every word carry a small type code. Besides the sum or difference it returns negative, zero, carry and overflow condition codes. The overflow code covers two things: a signed result that does not fit in the word, and an operand whose type code does not mark it as an integer. Software can therefore test a single condition after the operation and drop to a slow path that inspects the operand types.

A subtract can stand in for a comparison, since its condition codes feed later conditional branches or traps. A per-operation trap select turns an overflow condition into a trap request. When that happens, the destination register write is withheld for that operation. Results and condition codes are registered. A valid output follows a valid input by one clock.

Top module: `tagged_arith_unit`

## Requirements
- R1: Bits [1:0] of each operand form its type code, and the code 2'b00 means integer. No other bits take part in the type check.
- R2: For both add and subtract, `flag_v` is 1 when either operand's type code is not 2'b00, whatever the arithmetic outcome.
- R3: `flag_v` is also 1 when the two's-complement result overflows 32 bits. For add this means both operands have the same sign and the result sign differs from it. For subtract it means the operands differ in sign and the result sign differs from `opnd_a`.
- R4: `result` equals `opnd_a + opnd_b` (when `op_sub`=0) or `opnd_a - opnd_b` (when `op_sub`=1), modulo 2^32. The type codes do not change it.
- R5: `flag_n` equals `result[31]`. `flag_z` is 1 exactly when `result` is zero.
- R6: For add, `flag_c` is the carry out of bit 31. For subtract, `flag_c` is 1 when `opnd_a` >= `opnd_b` as unsigned numbers (no borrow).
- R7: `out_valid` is 1 in the cycle after a cycle with `in_valid`=1, and 0 after a cycle with `in_valid`=0. Back-to-back inputs give back-to-back outputs.
- R8: With `trap_en`=1 and overflow raised, `trap` is 1 and `wr_en` is 0 in the output cycle.
- R9: With `trap_en`=0, an accepted operation gives `wr_en`=1 and `trap`=0 even when `flag_v`=1. With `trap_en`=1 and no overflow, `wr_en`=1 and `trap`=0.
- R10: After reset, `out_valid`, `trap`, `wr_en`, `result` and all four flags are 0.
- R11: A cycle with `in_valid`=0 leaves `result` and the four flags unchanged, and `trap` and `wr_en` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sub | input | 1 | 0 selects add, 1 selects subtract (a - b) |
| trap_en | input | 1 | Request a trap instead of a write when overflow is raised |
| opnd_a | input | 32 | First operand; bits [1:0] are its type code |
| opnd_b | input | 32 | Second operand; bits [1:0] are its type code |
| out_valid | output | 1 | Registered result and flags are fresh |
| result | output | 32 | Registered sum or difference |
| flag_n | output | 1 | Negative condition code |
| flag_z | output | 1 | Zero condition code |
| flag_c | output | 1 | Carry / no-borrow condition code |
| flag_v | output | 1 | Overflow or non-integer operand condition code |
| trap | output | 1 | Trap request for this output cycle |
| wr_en | output | 1 | Destination write enable for this output cycle |

## Verification
The hardest case to reach is the one where type-code overflow and arithmetic overflow must be told apart. Integer-coded operands never set `flag_v` except through a genuine signed overflow. A bad type code must set it even when the sum is small. The stimulus sets up both cases on purpose: operands near the positive and negative limits with clean type codes, and small operands with a non-zero code on only one side, each under add and subtract. The trap select is then flipped on the same values, so the withheld write shows up at `wr_en` and `trap`.

// File: rtl/tagarith_pkg.sv
package tagarith_pkg;

   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
      logic ovf;
   } cond_codes_t;

   localparam cond_codes_t CC_CLEAR = '{neg: 1'b0, zero: 1'b0, carry: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/tagarith_tag_check.sv
module tagarith_tag_check #(
   parameter int unsigned TAG_W   = 2,
   parameter int unsigned INT_TAG = 0
) (
   input  logic [TAG_W-1:0] tag_bits,
   output logic             is_int
);
   localparam logic [TAG_W-1:0] INT_CODE = TAG_W'(INT_TAG);

   assign is_int = (tag_bits == INT_CODE);
endmodule

// File: rtl/tagarith_adder.sv
module tagarith_adder #(
   parameter int unsigned DATA_W        = 32,
   parameter bit          CARRY_SELECT  = 1'b0,
   parameter int unsigned SLICE_W       = 8
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);
   localparam int unsigned NSLICE = DATA_W / SLICE_W;

   if (CARRY_SELECT) begin : g_csel
      if (DATA_W % SLICE_W != 0) begin : g_bad_slice
         $error("tagarith_adder: DATA_W must be a multiple of SLICE_W");
      end
      logic [NSLICE:0] chain;
      assign chain[0] = cin;
      for (genvar i = 0; i < NSLICE; i++) begin : g_slice
         logic [SLICE_W:0] s0;
         logic [SLICE_W:0] s1;
         assign s0 = {1'b0, lhs[i*SLICE_W +: SLICE_W]} + {1'b0, rhs[i*SLICE_W +: SLICE_W]};
         assign s1 = s0 + (SLICE_W+1)'(1);
         assign sum[i*SLICE_W +: SLICE_W] = chain[i] ? s1[SLICE_W-1:0] : s0[SLICE_W-1:0];
         assign chain[i+1] = chain[i] ? s1[SLICE_W] : s0[SLICE_W];
      end
      assign cout = chain[NSLICE];
   end else begin : g_plain
      logic [DATA_W:0] wide;
      assign wide = {1'b0, lhs} + {1'b0, rhs} + {{DATA_W{1'b0}}, cin};
      assign sum  = wide[DATA_W-1:0];
      assign cout = wide[DATA_W];
   end
endmodule

// File: rtl/tagarith_flags.sv
module tagarith_flags
   import tagarith_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] sum,
   input  logic              cout,
   input  logic              sign_a,
   input  logic              sign_b_eff,
   input  logic              both_int,
   input  logic              trap_en,
   output cond_codes_t       cc,
   output logic              trap_req
);
   localparam int unsigned MSB = DATA_W - 1;

   logic arith_ovf;

   always_comb begin
      arith_ovf = (sign_a == sign_b_eff) && (sum[MSB] != sign_a);
      cc.neg    = sum[MSB];
      cc.zero   = (sum == '0);
      cc.carry  = cout;
      cc.ovf    = arith_ovf || !both_int;
      trap_req  = trap_en && cc.ovf;
   end
endmodule

// File: rtl/tagged_arith_unit.sv
module tagged_arith_unit
   import tagarith_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned TAG_W        = 2,
   parameter int unsigned INT_TAG      = 0,
   parameter bit          CARRY_SELECT = 1'b0,
   parameter int unsigned SLICE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              op_sub,
   input  logic              trap_en,
   input  logic [31:0]       opnd_a,
   input  logic [31:0]       opnd_b,
   output logic              out_valid,
   output logic [31:0]       result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v,
   output logic              trap,
   output logic              wr_en
);
   localparam int unsigned MSB   = DATA_W - 1;
   localparam int unsigned N_OPS = 2;

   if (DATA_W != 32) begin : g_bad_width
      $error("tagged_arith_unit: ports are 32 bits wide, DATA_W must be 32");
   end
   if (TAG_W == 0 || TAG_W >= DATA_W) begin : g_bad_tag
      $error("tagged_arith_unit: TAG_W must be between 1 and DATA_W-1");
   end
   if (INT_TAG >= (1 << TAG_W)) begin : g_bad_code
      $error("tagged_arith_unit: INT_TAG does not fit in TAG_W bits");
   end

   logic [DATA_W-1:0] ops [N_OPS];
   logic [N_OPS-1:0]  is_int;
   logic [DATA_W-1:0] rhs_eff;
   logic [DATA_W-1:0] sum;
   logic              cout;
   cond_codes_t       cc_d;
   cond_codes_t       cc_q;
   logic              trap_req;
   logic [DATA_W-1:0] result_q;
   logic              valid_q;
   logic              trap_q;
   logic              wr_q;

   assign ops[0] = opnd_a;
   assign ops[1] = opnd_b;

   for (genvar k = 0; k < N_OPS; k++) begin : g_tag
      tagarith_tag_check #(
         .TAG_W  (TAG_W),
         .INT_TAG(INT_TAG)
      ) u_tag (
         .tag_bits(ops[k][TAG_W-1:0]),
         .is_int  (is_int[k])
      );
   end

   assign rhs_eff = op_sub ? ~opnd_b : opnd_b;

   tagarith_adder #(
      .DATA_W      (DATA_W),
      .CARRY_SELECT(CARRY_SELECT),
      .SLICE_W     (SLICE_W)
   ) u_adder (
      .lhs (opnd_a),
      .rhs (rhs_eff),
      .cin (op_sub),
      .sum (sum),
      .cout(cout)
   );

   tagarith_flags #(
      .DATA_W(DATA_W)
   ) u_flags (
      .sum       (sum),
      .cout      (cout),
      .sign_a    (opnd_a[MSB]),
      .sign_b_eff(rhs_eff[MSB]),
      .both_int  (&is_int),
      .trap_en   (trap_en),
      .cc        (cc_d),
      .trap_req  (trap_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         trap_q   <= 1'b0;
         wr_q     <= 1'b0;
         result_q <= '0;
         cc_q     <= CC_CLEAR;
      end else begin
         valid_q <= in_valid;
         trap_q  <= in_valid && trap_req;
         wr_q    <= in_valid && !trap_req;
         if (in_valid) begin
            result_q <= sum;
            cc_q     <= cc_d;
         end
      end
   end

   assign out_valid = valid_q;
   assign result    = result_q;
   assign flag_n    = cc_q.neg;
   assign flag_z    = cc_q.zero;
   assign flag_c    = cc_q.carry;
   assign flag_v    = cc_q.ovf;
   assign trap      = trap_q;
   assign wr_en     = wr_q;
endmodule

// File: rtl/tagged_arith_chk.sv
module tagged_arith_chk #(
   parameter int unsigned TAG_W   = 2,
   parameter int unsigned INT_TAG = 0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        op_sub,
   input logic        trap_en,
   input logic [31:0] opnd_a,
   input logic [31:0] opnd_b,
   input logic        out_valid,
   input logic [31:0] result,
   input logic        flag_n,
   input logic        flag_z,
   input logic        flag_c,
   input logic        flag_v,
   input logic        trap,
   input logic        wr_en
);
   localparam logic [TAG_W-1:0] INT_CODE = TAG_W'(INT_TAG);

   logic bad_tag;
   assign bad_tag = (opnd_a[TAG_W-1:0] != INT_CODE) || (opnd_b[TAG_W-1:0] != INT_CODE);

   p_tag_sets_v_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && bad_tag |=> flag_v);

   p_pos_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !op_sub && !opnd_a[31] && !opnd_b[31] |=> (result[31] == flag_v) || flag_v);

   p_sub_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_sub && (opnd_a == opnd_b) |=> flag_z && !flag_n);

   p_no_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_sub |=> flag_c == ($past(opnd_a) >= $past(opnd_b)));

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_trap_on_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && trap_en && bad_tag |=> trap && !wr_en);

   p_trap_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap && wr_en));

   p_no_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !trap_en |=> wr_en && !trap);

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !trap && !wr_en && $stable(result) && $stable(flag_v));
endmodule

bind tagged_arith_unit tagged_arith_chk #(
   .TAG_W  (TAG_W),
   .INT_TAG(INT_TAG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op_sub   (op_sub),
   .trap_en  (trap_en),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .out_valid(out_valid),
   .result   (result),
   .flag_n   (flag_n),
   .flag_z   (flag_z),
   .flag_c   (flag_c),
   .flag_v   (flag_v),
   .trap     (trap),
   .wr_en    (wr_en)
);

// File: tb/tagged_arith_unit_tb.sv
module tagged_arith_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op_sub = 1'b0;
   logic        trap_en = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        flag_n, flag_z, flag_c, flag_v;
   logic        trap, wr_en;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   tagged_arith_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
      .trap_en(trap_en), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .out_valid(out_valid), .result(result), .flag_n(flag_n),
      .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
      .trap(trap), .wr_en(wr_en)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Model built from R2..R6 and R8/R9.
   task automatic expect_op(input string req, input logic [31:0] a, input logic [31:0] b,
                            input logic sub, input logic ten);
      logic [32:0] wide;
      logic [31:0] r;
      logic        ov, v, c;
      wide = sub ? ({1'b0, a} + {1'b0, ~b} + 33'd1) : ({1'b0, a} + {1'b0, b});
      r    = wide[31:0];
      c    = wide[32];
      ov   = sub ? ((a[31] != b[31]) && (r[31] != a[31])) : ((a[31] == b[31]) && (r[31] != a[31]));
      v    = ov || (a[1:0] != 2'b00) || (b[1:0] != 2'b00);
      chk(req, "out_valid R7", {31'd0, out_valid}, 32'd1);
      chk(req, "result R4", result, r);
      chk(req, "flag_n R5", {31'd0, flag_n}, {31'd0, r[31]});
      chk(req, "flag_z R5", {31'd0, flag_z}, {31'd0, r == 32'd0});
      chk(req, "flag_c R6", {31'd0, flag_c}, {31'd0, c});
      chk(req, "flag_v R2/R3", {31'd0, flag_v}, {31'd0, v});
      chk(req, "trap R8", {31'd0, trap}, {31'd0, ten && v});
      chk(req, "wr_en R9", {31'd0, wr_en}, {31'd0, !(ten && v)});
   endtask

   task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic sub, input logic ten);
      opnd_a = a; opnd_b = b; op_sub = sub; trap_en = ten; in_valid = 1'b1;
   endtask

   // One operation: drive at a falling edge, sample at the next falling edge.
   task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic sub, input logic ten);
      @(negedge clk);
      drive(a, b, sub, ten);
      @(negedge clk);
      in_valid = 1'b0;
      expect_op(req, a, b, sub, ten);
   endtask

   task automatic t_reset;
      chk("R10", "out_valid", {31'd0, out_valid}, 32'd0);
      chk("R10", "result", result, 32'd0);
      chk("R10", "flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
      chk("R10", "trap/wr_en", {30'd0, trap, wr_en}, 32'd0);
   endtask

   task automatic t_plain_add;
      run_op("R4", 32'h0000_0010, 32'h0000_0024, 1'b0, 1'b0);
      run_op("R6", 32'hFFFF_FFFC, 32'h0000_0008, 1'b0, 1'b0);   // carry out, result 4
   endtask

   task automatic t_compare;
      run_op("R6", 32'h0000_0100, 32'h0000_0040, 1'b1, 1'b0);   // a > b
      run_op("R5", 32'h0000_1234 & 32'hFFFF_FFFC, 32'h0000_1234 & 32'hFFFF_FFFC, 1'b1, 1'b0);
      run_op("R5", 32'h0000_0040, 32'h0000_0100, 1'b1, 1'b0);   // borrow, negative
   endtask

   task automatic t_arith_ovf;
      run_op("R3", 32'h7FFF_FFFC, 32'h0000_0004, 1'b0, 1'b0);
      run_op("R3", 32'h8000_0000, 32'h0000_0004, 1'b1, 1'b0);
      run_op("R3", 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);   // zero with overflow
   endtask

   task automatic t_tags;
      run_op("R1", 32'h0000_0011, 32'h0000_0008, 1'b0, 1'b0);   // bad code on a only
      run_op("R2", 32'h0000_0020, 32'h0000_0006, 1'b1, 1'b0);   // bad code on b, subtract
      run_op("R1", 32'h0000_0F00, 32'h0000_0104, 1'b0, 1'b0);   // bit 2 set, still integer
   endtask

   task automatic t_trap;
      run_op("R8", 32'h0000_0020, 32'h0000_0002, 1'b0, 1'b1);
      run_op("R8", 32'h7FFF_FFFC, 32'h0000_0004, 1'b0, 1'b1);
      run_op("R9", 32'h0000_0020, 32'h0000_0004, 1'b1, 1'b1);   // trap select, no overflow
      run_op("R9", 32'h0000_0023, 32'h0000_0004, 1'b0, 1'b0);   // bad code, no trap select
   endtask

   task automatic t_idle_hold;
      logic [31:0] r_prev;
      logic [3:0]  f_prev;
      run_op("R11", 32'h0000_0050, 32'h0000_0003, 1'b1, 1'b1);
      r_prev = result;
      f_prev = {flag_n, flag_z, flag_c, flag_v};
      // idle cycle with junk on the operand pins
      opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h1234_5677; op_sub = 1'b0; trap_en = 1'b1;
      @(negedge clk);
      chk("R11", "out_valid idle", {31'd0, out_valid}, 32'd0);
      chk("R11", "result held", result, r_prev);
      chk("R11", "flags held", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, f_prev});
      chk("R11", "trap/wr_en idle", {30'd0, trap, wr_en}, 32'd0);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      drive(32'h0000_0400, 32'h0000_0100, 1'b0, 1'b0);
      #1;
      chk("R7", "no output before edge", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      expect_op("R7", 32'h0000_0400, 32'h0000_0100, 1'b0, 1'b0);
      drive(32'h0000_0400, 32'h0000_0400, 1'b1, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      expect_op("R7", 32'h0000_0400, 32'h0000_0400, 1'b1, 1'b1);
      @(negedge clk);
      chk("R7", "out_valid drops", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain_add();
      t_compare();
      t_arith_ovf();
      t_tags();
      t_trap();
      t_idle_hold();
      t_back_to_back();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule